// File: doc/BRIEF.md
# Address Decode Error Capture Unit

This unit sits beside a memory controller and watches each transaction the controller accepts. It flags two kinds of illegal access. The first is an address that none of the programmed decode windows claims. The second is a burst, or any request longer than eight bytes, aimed at a bank that is only 8 or 16 bits wide. For each kind of error the unit keeps a sticky cause flag. It can raise an interrupt, gated by a per-flag enable. It also keeps the address of the offending transaction in a register that software can read.

The unit does no decoding of its own. For each window the controller reports whether that window hit and whether its bank is narrow. When several windows hit, the lowest-numbered one decides the bank width. Software uses a small register port to read and clear the cause flags, to set the enables and to read the captured address. Two interlocks are released by separate software actions. A set cause flag holds the interrupt until software clears that flag. The captured address stays frozen until software reads it.

Top module: `addr_err_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the cause flags, the enables, the captured address and `irq` all become 0, and address capture is armed.
- R2: A cycle with `txn_valid` high and no bit of `win_hit` set sets cause bit 0 (miss).
- R3: A cycle with `txn_valid` high whose lowest-index hitting window has its `win_narrow` bit set, and with `txn_burst` high, sets cause bit 1 (narrow violation).
- R4: A non-burst request to a narrow target sets cause bit 1 only when `txn_len` exceeds 8 bytes. Bursts or long requests to a wide target set nothing. When several windows hit, only the lowest index decides the width.
- R5: The cause flags are sticky. Writing register select 0 clears each bit written as 0 and leaves each bit written as 1 unchanged. An error in the same cycle as a clearing write leaves its bit set.
- R6: `irq` is a register that, after each edge, equals the OR over bits of cause AND enable. The enables come from register select 1, bits [1:0], and reset to 0, which means masked.
- R7: While an enabled cause flag stays set, further errors raise no new interrupt and `irq` stays high. After software clears the flag, the next error raises `irq` again.
- R8: The first error after capture is armed stores the full 32-bit `txn_addr` and disarms capture. Later errors leave the stored address unchanged, and so does a look at register select 2 with `reg_rd` low.
- R9: A cycle with `reg_rd` high and select 2 returns the stored address and re-arms capture from the next edge. An error in that same cycle is captured.
- R10: `reg_rdata` is driven combinationally. Select 0 returns the cause flags in bits [1:0], select 1 the enables, select 2 the address and select 3 zero, and all unused bits read 0. Cycles with `txn_valid` low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_burst | input | 1 | Transaction is a burst |
| txn_len | input | 8 | Requested length in bytes |
| win_hit | input | 4 | Per-window hit from the controller's decoder |
| win_narrow | input | 4 | Per-window bank width is 8 or 16 bits |
| reg_sel | input | 2 | Register select: 0 cause, 1 enable, 2 address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (affects select 2 only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request, registered |

## Verification
On every cycle the assertions check four things. The interrupt always matches the cause flags ANDed with the enables. A cause flag never drops unless a cause write happens. The stored address never moves while capture is disarmed and no read is made. A miss always sets the miss flag. The bench scenarios cover what depends on order and data. These include the choice of the lowest-index window, the 8-byte length limit, which address out of a run of errors is the one kept, re-arming after a read including an error in the read cycle, and a new interrupt after a clear.

// File: rtl/aec_pkg.sv
// Package: shared constants and types for the address decode error unit.
// Assumes: two cause sources, each with one enable bit at the same position.
package aec_pkg;
    localparam int CAUSE_W    = 2;
    localparam int BIT_MISS   = 0;
    localparam int BIT_NARROW = 1;

    typedef logic [CAUSE_W-1:0] cause_t;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/aec_classify.sv
// Module: aec_classify
// Turns one observed transaction into a per-source error vector.
// Assumes: win_hit and win_narrow are valid whenever txn_valid is high.
// When several windows hit, the lowest index decides the bank width.
module aec_classify
    import aec_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int LEN_W     = 8,
    parameter int MAX_BYTES = 8
) (
    input  logic               txn_valid,
    input  logic               txn_burst,
    input  logic [LEN_W-1:0]   txn_len,
    input  logic [NUM_WIN-1:0] win_hit,
    input  logic [NUM_WIN-1:0] win_narrow,
    output cause_t             err_vec
);
    logic [NUM_WIN:0] found;
    logic [NUM_WIN:0] narrow_chain;
    logic             any_hit;
    logic             tgt_narrow;
    logic             oversize;

    assign found[0]        = 1'b0;
    assign narrow_chain[0] = 1'b0;

    // Priority chain: the first hitting window fixes the target width.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_prio
        assign found[g+1]        = found[g] | win_hit[g];
        assign narrow_chain[g+1] = found[g] ? narrow_chain[g]
                                            : (win_hit[g] & win_narrow[g]);
    end

    assign any_hit    = found[NUM_WIN];
    assign tgt_narrow = narrow_chain[NUM_WIN];
    assign oversize   = txn_len > LEN_W'(MAX_BYTES);

    // Error classification for the current cycle.
    always_comb begin
        err_vec             = '0;
        err_vec[BIT_MISS]   = txn_valid & ~any_hit;
        err_vec[BIT_NARROW] = txn_valid & any_hit & tgt_narrow
                              & (txn_burst | oversize);
    end
endmodule

// File: rtl/aec_cause_reg.sv
// Module: aec_cause_reg
// Holds the sticky cause flags, the enables and the registered interrupt.
// Assumes: a write to the cause flags clears bits written 0, and a new error
// in the same cycle takes priority over the clear.
module aec_cause_reg
    import aec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t err_vec,
    input  logic   cause_wr,
    input  logic   mask_wr,
    input  cause_t wdata,
    output cause_t cause_q,
    output cause_t mask_q,
    output logic   irq_q
);
    cause_t cause_d;
    cause_t mask_d;

    // Next state: clear by written zeros, then merge new errors.
    always_comb begin
        cause_d = (cause_wr ? (cause_q & wdata) : cause_q) | err_vec;
        mask_d  = mask_wr ? wdata : mask_q;
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
            irq_q   <= |(cause_d & mask_d);
        end
    end
endmodule

// File: rtl/aec_addr_capture.sv
// Module: aec_addr_capture
// Stores the address of the first error while armed. A read of the address
// re-arms capture. An error in the read cycle is itself captured.
// Assumes: addr_rd is a single-cycle strobe from the register port.
module aec_addr_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_any,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              addr_rd,
    output logic [ADDR_W-1:0] err_addr_q,
    output logic              armed_q
);
    logic take;

    assign take = err_any & (armed_q | addr_rd);

    // Capture on the first armed error, and re-arm on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr_q <= '0;
            armed_q    <= 1'b1;
        end else if (take) begin
            err_addr_q <= txn_addr;
            armed_q    <= 1'b0;
        end else if (addr_rd) begin
            armed_q    <= 1'b1;
        end
    end
endmodule

// File: rtl/addr_err_capture.sv
// Module: addr_err_capture (top)
// Watches memory transactions, flags misses and narrow-bank violations,
// keeps sticky cause flags, enables, an interrupt and the error address.
// Assumes: the decode hit and width flags come from the controller's decoder.
module addr_err_capture
    import aec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 8,
    parameter int NUM_WIN   = 4,
    parameter int MAX_BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_valid,
    input  logic [ADDR_W-1:0]  txn_addr,
    input  logic               txn_burst,
    input  logic [LEN_W-1:0]   txn_len,
    input  logic [NUM_WIN-1:0] win_hit,
    input  logic [NUM_WIN-1:0] win_narrow,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    reg_sel_e          sel;
    cause_t            err_vec;
    cause_t            cause_q;
    cause_t            mask_q;
    cause_t            wdata_c;
    logic              cause_wr;
    logic              mask_wr;
    logic              addr_rd;
    logic              armed_q;
    logic [ADDR_W-1:0] err_addr_q;
    logic              unused_wdata_hi;

    assign sel             = reg_sel_e'(reg_sel);
    assign wdata_c         = reg_wdata[CAUSE_W-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CAUSE_W];
    assign cause_wr        = reg_wr & (sel == SEL_CAUSE);
    assign mask_wr         = reg_wr & (sel == SEL_MASK);
    assign addr_rd         = reg_rd & (sel == SEL_ADDR);

    aec_classify #(
        .NUM_WIN  (NUM_WIN),
        .LEN_W    (LEN_W),
        .MAX_BYTES(MAX_BYTES)
    ) u_classify (
        .txn_valid (txn_valid),
        .txn_burst (txn_burst),
        .txn_len   (txn_len),
        .win_hit   (win_hit),
        .win_narrow(win_narrow),
        .err_vec   (err_vec)
    );

    aec_cause_reg u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_vec (err_vec),
        .cause_wr(cause_wr),
        .mask_wr (mask_wr),
        .wdata   (wdata_c),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .irq_q   (irq)
    );

    aec_addr_capture #(
        .ADDR_W(ADDR_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_any   (|err_vec),
        .txn_addr  (txn_addr),
        .addr_rd   (addr_rd),
        .err_addr_q(err_addr_q),
        .armed_q   (armed_q)
    );

    // Register read multiplexer, with unused bits tied to zero.
    always_comb begin
        unique case (sel)
            SEL_CAUSE: reg_rdata = DATA_W'(cause_q);
            SEL_MASK:  reg_rdata = DATA_W'(mask_q);
            SEL_ADDR:  reg_rdata = DATA_W'(err_addr_q);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/aec_checker.sv
// Module: aec_checker
// Cycle-level properties of addr_err_capture, attached by bind.
// Assumes: the default widths of the top (2 cause bits).
module aec_checker #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               txn_valid,
    input logic [NUM_WIN-1:0] win_hit,
    input logic [1:0]         reg_sel,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic               irq,
    input logic [1:0]         cause,
    input logic [1:0]         mask,
    input logic               armed,
    input logic [ADDR_W-1:0]  err_addr
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cause == 2'b00 && mask == 2'b00 && !irq && armed));

    // R2
    miss_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && win_hit == '0) |=> cause[0]);

    // R5
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == 2'd0) |=> ((cause & $past(cause)) == $past(cause)));

    // R6
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(cause & mask));

    // R8
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !(reg_rd && reg_sel == 2'd2)) |=> $stable(err_addr));

    // R9
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd2 && !txn_valid) |=> armed);
endmodule

bind addr_err_capture aec_checker #(
    .ADDR_W (ADDR_W),
    .NUM_WIN(NUM_WIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txn_valid(txn_valid),
    .win_hit  (win_hit),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .irq      (irq),
    .cause    (cause_q),
    .mask     (mask_q),
    .armed    (armed_q),
    .err_addr (err_addr_q)
);

// File: tb/addr_err_capture_bench.sv
`timescale 1ns/1ps
module addr_err_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        txn_burst = 1'b0;
    logic [7:0]  txn_len = '0;
    logic [3:0]  win_hit = '0;
    logic [3:0]  win_narrow = '0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_err_capture u_addr_err_capture (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_burst(txn_burst), .txn_len(txn_len), .win_hit(win_hit),
        .win_narrow(win_narrow), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic       valid;
        logic [3:0] hit;
        logic [3:0] narrow;
        logic       burst;
        logic [7:0] len;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'b0000, 4'b0000, 1'b0, 8'd4,  2'b01}, // R2 miss
        '{1'b1, 4'b0001, 4'b0000, 1'b1, 8'd32, 2'b00}, // R4 wide burst legal
        '{1'b1, 4'b0010, 4'b0010, 1'b1, 8'd8,  2'b10}, // R3 narrow burst
        '{1'b1, 4'b0100, 4'b0100, 1'b0, 8'd8,  2'b00}, // R4 8 bytes ok
        '{1'b1, 4'b0100, 4'b0100, 1'b0, 8'd9,  2'b10}, // R4 9 bytes too long
        '{1'b1, 4'b0110, 4'b0100, 1'b1, 8'd16, 2'b00}, // R4 lowest index wide
        '{1'b1, 4'b1100, 4'b0100, 1'b1, 8'd4,  2'b10}, // R4 lowest index narrow
        '{1'b0, 4'b0000, 4'b0000, 1'b0, 8'd4,  2'b00}, // R10 invalid ignored
        '{1'b1, 4'b1000, 4'b1000, 1'b0, 8'd1,  2'b00}  // R4 single narrow
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One cycle of stimulus starting at a negedge; ends at the next negedge.
    task automatic cyc(input logic v, input logic [31:0] a, input logic [3:0] h,
                       input logic [3:0] n, input logic b, input logic [7:0] l,
                       input logic w, input logic r, input logic [1:0] s,
                       input logic [31:0] d);
        txn_valid = v; txn_addr = a; win_hit = h; win_narrow = n;
        txn_burst = b; txn_len = l; reg_wr = w; reg_rd = r; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        txn_valid = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic miss(input logic [31:0] a);
        cyc(1'b1, a, 4'b0000, 4'b0000, 1'b0, 8'd4, 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cyc(1'b0, 32'h0, 4'b0001, 4'b0000, 1'b0, 8'd0, 1'b1, 1'b0, s, d);
    endtask

    task automatic peek(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s; reg_rd = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        peek(2'd0, v); check("R1 cause", v, 32'h0);
        peek(2'd1, v); check("R1 mask", v, 32'h0);
        peek(2'd2, v); check("R1 addr", v, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;

        // Vector table: classification (R2 R3 R4 R10)
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].valid, 32'h100 + i, VEC[i].hit, VEC[i].narrow,
                VEC[i].burst, VEC[i].len, 1'b0, 1'b0, 2'd0, 32'h0);
            peek(2'd0, v);
            check($sformatf("R2/R3/R4 vector %0d", i), v, {30'h0, VEC[i].exp});
            wr(2'd0, 32'h0);
        end

        do_reset();
        // R8 first capture, masked interrupt R6
        miss(32'hA000_0010);
        peek(2'd2, v); check("R8 first addr", v, 32'hA000_0010);
        check("R6 masked irq", {31'h0, irq}, 32'h0);
        miss(32'hB000_0020);
        peek(2'd2, v); check("R8 frozen", v, 32'hA000_0010);
        peek(2'd2, v); check("R8 peek no rearm", v, 32'hA000_0010);
        wr(2'd1, 32'h1);
        check("R6 enable raises irq", {31'h0, irq}, 32'h1);
        // R7 interlock
        miss(32'hC000_0000);
        check("R7 irq held", {31'h0, irq}, 32'h1);
        wr(2'd0, 32'h2);
        peek(2'd0, v); check("R5 clear by zero", v, 32'h0);
        check("R7 irq drops", {31'h0, irq}, 32'h0);
        miss(32'hC000_0004);
        check("R7 irq again", {31'h0, irq}, 32'h1);
        peek(2'd2, v); check("R8 still frozen", v, 32'hA000_0010);
        // R5 write one keeps, error beats clear
        wr(2'd0, 32'h3);
        peek(2'd0, v); check("R5 write one", v, 32'h1);
        cyc(1'b1, 32'hD, 4'b0000, 4'b0000, 1'b0, 8'd4, 1'b1, 1'b0, 2'd0, 32'h0);
        peek(2'd0, v); check("R5 error beats clear", v, 32'h1);
        // R9 read re-arms
        txn_valid = 1'b0; reg_sel = 2'd2; reg_rd = 1'b1;
        #1 check("R9 read data", reg_rdata, 32'hA000_0010);
        @(negedge clk); reg_rd = 1'b0;
        miss(32'hD000_0040);
        peek(2'd2, v); check("R9 recapture", v, 32'hD000_0040);
        cyc(1'b1, 32'hE000_0050, 4'b0000, 4'b0000, 1'b0, 8'd4, 1'b0, 1'b1, 2'd2, 32'h0);
        peek(2'd2, v); check("R9 same-cycle capture", v, 32'hE000_0050);
        miss(32'hF000_0060);
        peek(2'd2, v); check("R9 disarmed after", v, 32'hE000_0050);
        // R10 register map
        peek(2'd3, v); check("R10 unused select", v, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        peek(2'd1, v); check("R10 mask width", v, 32'h3);
        cyc(1'b0, 32'h0, 4'b0000, 4'b0000, 1'b0, 8'd4, 1'b1, 1'b0, 2'd0, 32'h0);
        cyc(1'b0, 32'h0, 4'b0000, 4'b0000, 1'b0, 8'd4, 1'b0, 1'b0, 2'd0, 32'h0);
        peek(2'd0, v); check("R10 invalid ignored", v, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule